// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs a single memory or I/O transfer on a bus whose low address bits and data share the same pins. A requester presents an address, a direction, a memory-or-I/O choice, a word/byte size and, for writes, the data. The sequencer then steps through four phases. In the first phase it drives the address with an address-latch strobe. In the middle phases it asserts the read or write strobe and the data-buffer enable. In the last phase it releases everything. A slow responder can stretch the transfer by holding the ready input low, which adds wait phases.

Read data is taken from the shared pins as the third phase closes. It is handed back with a one-cycle done pulse in the fourth phase. The upper-byte enable goes low whenever the upper half of the 16-bit data path takes part. The memory/I/O pin is high for memory and low for I/O by default.

All pins are registered and change only at the rising clock edge. Each phase is one clock cycle. The shared bus is split into an output value, an output enable and an input value, so the pad ring decides how to tri-state it.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While reset is high, and in the cycle after it drops with no request: ale=0, rd_n=1, wr_n=1, den_n=1, ad_oe=0, done=0, bhe_n=1, req_ready=1.
- R2: The cycle after a request is accepted is T1. In T1, ale=1 for exactly that one cycle, ad_oe=1, ad_out=address[15:0], addr_hi=address[19:16], and rd_n, wr_n and den_n stay 1.
- R3: From T1 through T4, mio is 1 for a memory request (req_io=0) and 0 for an I/O request (req_io=1). Over the same phases, dtr is 1 for a write and 0 for a read.
- R4: From T1 through T4, bhe_n is 0 exactly when req_word=1 or address bit 0 is 1; otherwise it is 1.
- R5: For a read, in T2, every wait phase and T3: rd_n=0, wr_n=1, den_n=0 and ad_oe=0.
- R6: For a write, in T2, every wait phase and T3: wr_n=0, rd_n=1, den_n=0, ad_oe=1 and ad_out=write data.
- R7: If ready is 0 at the clock edge that closes T2 or a wait phase, one more wait phase follows, and the strobes keep their values. If ready is 1 at that edge, T3 follows.
- R8: For a read, the value on ad_in at the edge that closes T3 appears on rdata in T4. done is 1 for the single T4 cycle of every transfer and 0 otherwise.
- R9: In T4, rd_n=1, wr_n=1, den_n=1 and ad_oe=0.
- R10: req_ready is 1 only in idle and in T4. A request raised while req_ready=0 is ignored: no ale follows it. A request accepted in T4 starts T1 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request is taken at this edge if req_valid is high |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| req_wdata | input | DATA_W | Write data |
| ready | input | 1 | Responder ready; 0 adds a wait phase |
| ad_in | input | DATA_W | Value read back from the shared pins |
| ad_out | output | DATA_W | Value driven onto the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| addr_hi | output | ADDR_W-DATA_W | Upper address bits |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dtr | output | 1 | Buffer direction, 1 = transmit |
| mio | output | 1 | Memory/I/O select |
| bhe_n | output | 1 | Upper-byte enable, active low |
| done | output | 1 | Transfer-finished pulse in T4 |
| rdata | output | DATA_W | Captured read data |

## Verification
The request is taken at a rising edge, and the pins show T1 one cycle later. Each further phase costs one more cycle, plus one per wait phase while ready is low. done and rdata are therefore due three cycles after T1 plus the number of wait phases.

The bench drives its inputs and samples the outputs on the falling edge. It moves through the transfer one falling edge at a time and checks the phase that is due at each step. It sets ready high only at the falling edge inside the last wait phase it wants, so it knows exactly which edge ends the stretch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // One value per bus phase; one phase lasts one clock cycle.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready,
  output phase_e state,
  output phase_e nxt,
  output logic   req_ready,
  output logic   accept
);

  // New work may start from idle or straight after the release phase.
  assign req_ready = (state == PH_IDLE) || (state == PH_T4);
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      PH_IDLE: nxt = accept ? PH_T1 : PH_IDLE;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = ready ? PH_T3 : PH_TW;
      PH_TW:   nxt = ready ? PH_T3 : PH_TW;
      PH_T3:   nxt = PH_T4;
      PH_T4:   nxt = accept ? PH_T1 : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_IDLE;
    else     state <= nxt;
  end

  // R10: an accepted request always opens with the address phase.
  a_r10_accept_to_t1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (state == PH_T1));

  // R7: a low ready at the end of T2 or a wait phase yields another wait phase.
  a_r7_wait_inserted: assert property (@(posedge clk) disable iff (rst)
    (((state == PH_T2) || (state == PH_TW)) && !ready) |=> (state == PH_TW));

  // R7: a high ready at that point moves on to T3.
  a_r7_wait_ends: assert property (@(posedge clk) disable iff (rst)
    (((state == PH_T2) || (state == PH_TW)) && ready) |=> (state == PH_T3));

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter bit MEM_IS_HIGH = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  phase_e                   nxt,
  input  logic                     accept,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_word,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dtr,
  output logic                     mio,
  output logic                     bhe_n,
  output logic                     done
);

  localparam int HI_W = ADDR_W - DATA_W;

  // Request fields held for the whole transfer.
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_write;
  logic              lat_io;
  logic              lat_upper;

  // Fields that apply to the phase being entered.
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;
  logic              cur_io;
  logic              cur_upper;
  logic              space_lvl;

  assign cur_addr  = accept ? req_addr  : lat_addr;
  assign cur_wdata = accept ? req_wdata : lat_wdata;
  assign cur_write = accept ? req_write : lat_write;
  assign cur_io    = accept ? req_io    : lat_io;
  assign cur_upper = accept ? (req_word | req_addr[0]) : lat_upper;

  // Pin polarity of the memory/I/O select.
  generate
    if (MEM_IS_HIGH) begin : g_mem_high
      assign space_lvl = ~cur_io;
    end else begin : g_mem_low
      assign space_lvl = cur_io;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
      lat_io    <= 1'b0;
      lat_upper <= 1'b0;
    end else if (accept) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_write <= req_write;
      lat_io    <= req_io;
      lat_upper <= req_word | req_addr[0];
    end
  end

  // Strobe phases: T2, any wait phase, T3.
  logic strobe_ph;
  logic busy_ph;
  assign strobe_ph = (nxt == PH_T2) || (nxt == PH_TW) || (nxt == PH_T3);
  assign busy_ph   = (nxt != PH_IDLE);

  // Every pin is registered from the phase being entered.
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      den_n   <= 1'b1;
      dtr     <= 1'b0;
      mio     <= 1'b1;
      bhe_n   <= 1'b1;
      done    <= 1'b0;
    end else begin
      ale   <= (nxt == PH_T1);
      done  <= (nxt == PH_T4);
      rd_n  <= ~(strobe_ph && !cur_write);
      wr_n  <= ~(strobe_ph &&  cur_write);
      den_n <= ~strobe_ph;
      if (nxt == PH_T1) begin
        ad_out <= cur_addr[DATA_W-1:0];
        ad_oe  <= 1'b1;
      end else if (strobe_ph && cur_write) begin
        ad_out <= cur_wdata;
        ad_oe  <= 1'b1;
      end else begin
        ad_out <= '0;
        ad_oe  <= 1'b0;
      end
      if (busy_ph) begin
        addr_hi <= cur_addr[ADDR_W-1:DATA_W];
        dtr     <= cur_write;
        mio     <= space_lvl;
        bhe_n   <= ~cur_upper;
      end else begin
        dtr     <= 1'b0;
        bhe_n   <= 1'b1;
      end
    end
  end

  // R2: the address strobe never lasts two cycles in a row.
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R5: read and write strobes never overlap.
  a_r5_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n));

  // R6: the pins are driven whenever the write strobe is low.
  a_r6_write_drives: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  // R5: the pins are released whenever the read strobe is low.
  a_r5_read_releases: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  initial begin
    a_r2_width_ok: assert (HI_W > 0);
  end

endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            state,
  input  logic              dir_tx,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);

  // Sample the shared pins at the edge that closes T3 of a read.
  always_ff @(posedge clk) begin
    if (rst)                               rdata <= '0;
    else if ((state == PH_T3) && !dir_tx)  rdata <= ad_in;
  end

  // R8: read data only moves out of T3 of a read.
  a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    ((state != PH_T3) || dir_tx) |=> $stable(rdata));

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter bit MEM_IS_HIGH = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_word,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dtr,
  output logic                     mio,
  output logic                     bhe_n,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata
);

  phase_e state;
  phase_e nxt;
  logic   accept;

  mbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready     (ready),
    .state     (state),
    .nxt       (nxt),
    .req_ready (req_ready),
    .accept    (accept)
  );

  mbus_pin_drive #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MEM_IS_HIGH (MEM_IS_HIGH)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .nxt       (nxt),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_io    (req_io),
    .req_word  (req_word),
    .req_wdata (req_wdata),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dtr       (dtr),
    .mio       (mio),
    .bhe_n     (bhe_n),
    .done      (done)
  );

  mbus_rd_capture #(
    .DATA_W (DATA_W)
  ) u_rcap (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .dir_tx (dtr),
    .ad_in  (ad_in),
    .rdata  (rdata)
  );

  // R9: the finishing phase has every strobe and the bus released.
  a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && den_n && !ad_oe));

  // R8: done is a single-cycle pulse.
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a request raised while busy leaves no address strobe behind.
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && req_valid) |=> !ale);

  // R2: the address phase keeps all strobes inactive.
  a_r2_t1_quiet: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && den_n && ad_oe));

endmodule

// File: tb/sim_mbus_cycle_seq.sv
module sim_mbus_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_io = 1'b0;
  logic              req_word = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              ready = 1'b1;
  logic [DATA_W-1:0] ad_in = '0;
  logic [DATA_W-1:0] ad_out;
  logic              ad_oe;
  logic [HI_W-1:0]   addr_hi;
  logic              ale, rd_n, wr_n, den_n, dtr, mio, bhe_n, done;
  logic [DATA_W-1:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_cycle_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_word(req_word), .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr), .mio(mio),
    .bhe_n(bhe_n), .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Strobe phase checks: T2, wait phases, T3.
  task automatic chk_strobes(input bit wr, input logic [15:0] wd, input string ph);
    chk({"R5/R6 den_n ", ph}, den_n, 0);
    chk({"R7 done low ", ph}, done, 0);
    if (wr) begin
      chk({"R6 wr_n ", ph}, wr_n, 0);
      chk({"R6 rd_n ", ph}, rd_n, 1);
      chk({"R6 ad_oe ", ph}, ad_oe, 1);
      chk({"R6 ad_out ", ph}, ad_out, wd);
    end else begin
      chk({"R5 rd_n ", ph}, rd_n, 0);
      chk({"R5 wr_n ", ph}, wr_n, 1);
      chk({"R5 ad_oe ", ph}, ad_oe, 0);
    end
  endtask

  task automatic chk_status(input bit wr, input bit io, input bit exp_bhe, input string ph);
    chk({"R3 mio ", ph}, mio, io ? 0 : 1);
    chk({"R3 dtr ", ph}, dtr, wr);
    chk({"R4 bhe_n ", ph}, bhe_n, exp_bhe);
  endtask

  // One complete transfer with a chosen number of wait phases.
  task automatic run_cycle(input logic [19:0] a, input bit wr, input bit io, input bit word,
                           input logic [15:0] wd, input int nwait, input logic [15:0] resp);
    bit eb;
    eb = !(word || a[0]);
    @(negedge clk);
    req_addr = a; req_write = wr; req_io = io; req_word = word; req_wdata = wd;
    req_valid = 1'b1; ready = (nwait == 0);
    chk("R10 req_ready idle", req_ready, 1);
    @(negedge clk);                       // T1
    req_valid = 1'b0;
    chk("R2 ale T1", ale, 1);
    chk("R2 ad_oe T1", ad_oe, 1);
    chk("R2 ad_out T1", ad_out, a[15:0]);
    chk("R2 addr_hi T1", addr_hi, a[19:16]);
    chk("R2 strobes off T1", {rd_n, wr_n, den_n}, 3'b111);
    chk("R10 req_ready T1", req_ready, 0);
    chk_status(wr, io, eb, "T1");
    @(negedge clk);                       // T2
    chk("R2 ale T2", ale, 0);
    chk_strobes(wr, wd, "T2");
    for (int k = 0; k < nwait; k++) begin
      @(negedge clk);                     // Tw
      chk_strobes(wr, wd, "R7 Tw");
      chk("R10 req_ready Tw", req_ready, 0);
      if (k == nwait - 1) ready = 1'b1;
    end
    ad_in = resp;
    @(negedge clk);                       // T3
    chk_strobes(wr, wd, "T3");
    chk_status(wr, io, eb, "T3");
    @(negedge clk);                       // T4
    ad_in = 16'h0000;
    chk("R8 done T4", done, 1);
    if (!wr) chk("R8 rdata T4", rdata, resp);
    chk("R9 released T4", {rd_n, wr_n, den_n, ad_oe}, 4'b1110);
    chk("R10 req_ready T4", req_ready, 1);
    chk_status(wr, io, eb, "T4");
    @(negedge clk);                       // idle
    chk("R8 done idle", done, 0);
    chk("R10 no ale idle", ale, 0);
    ready = 1'b1;
  endtask

  task automatic test_reset;
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 done", done, 0);
    chk("R1 bhe_n", bhe_n, 1);
    chk("R1 req_ready", req_ready, 1);
  endtask

  // A request raised mid-transfer must be dropped.
  task automatic test_busy_ignore;
    @(negedge clk);
    req_addr = 20'h12340; req_write = 0; req_io = 0; req_word = 1; req_valid = 1; ready = 1;
    @(negedge clk);                       // T1
    req_valid = 1'b0;
    @(negedge clk);                       // T2
    req_addr = 20'hABCDE; req_valid = 1'b1;
    @(negedge clk);                       // T3
    req_valid = 1'b0;
    chk("R10 busy no ale T3", ale, 0);
    @(negedge clk);                       // T4
    chk("R10 done busy case", done, 1);
    @(negedge clk);                       // idle
    chk("R10 busy request dropped", ale, 0);
    @(negedge clk);
    chk("R10 still idle", ale, 0);
    chk("R10 ready again", req_ready, 1);
  endtask

  // Request accepted in T4 starts T1 the next cycle.
  task automatic test_back_to_back;
    @(negedge clk);
    req_addr = 20'h0F002; req_write = 1; req_io = 0; req_word = 1; req_wdata = 16'hBEEF;
    req_valid = 1; ready = 1;
    @(negedge clk); req_valid = 0;        // T1
    @(negedge clk);                       // T2
    @(negedge clk);                       // T3
    @(negedge clk);                       // T4
    chk("R10 b2b done", done, 1);
    req_addr = 20'h70456; req_write = 0; req_io = 1; req_word = 0; req_valid = 1;
    @(negedge clk);                       // T1 of second
    req_valid = 0;
    chk("R10 b2b ale", ale, 1);
    chk("R10 b2b addr", ad_out, 16'h0456);
    chk("R10 b2b dtr", dtr, 0);
    chk("R3 b2b mio io", mio, 0);
    chk("R4 b2b bhe even byte", bhe_n, 1);
    @(negedge clk);                       // T2
    ad_in = 16'h5A5A;
    @(negedge clk);                       // T3
    @(negedge clk);                       // T4
    chk("R8 b2b rdata", rdata, 16'h5A5A);
    @(negedge clk);
    ad_in = 16'h0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_cycle(20'hA1234, 0, 0, 1, 16'h0000, 0, 16'hC3A5);  // mem word read
    run_cycle(20'h00310, 1, 1, 0, 16'h00E7, 2, 16'h0000);  // io byte write, 2 waits
    run_cycle(20'h5F0A1, 0, 0, 0, 16'h0000, 1, 16'h7E00);  // odd byte read, 1 wait
    run_cycle(20'hFFFF0, 1, 0, 1, 16'h1357, 0, 16'h0000);  // mem word write
    run_cycle(20'h00061, 0, 1, 0, 16'h0000, 4, 16'h0081);  // io odd read, 4 waits
    test_busy_ignore();
    test_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule